// File: doc/BRIEF.md
# Edge-Triggered Interrupt Gateway

This block stands between one edge-triggered interrupt source and the core of a platform interrupt controller. It brings the raw interrupt line into the clock domain through a two-flop synchroniser and detects its rising edge. From the first rising edge on an idle source it produces a level request toward the core. Once a request has gone out, the gateway stays closed until the core reports that the handler has finished. A claim by the core only drops the request line; it does not open the gateway again.

A build-time parameter decides what happens to edges that arrive while a request is in flight. In ignore mode they are lost. In count mode each edge adds one to a saturating pending counter. After each completion the counter is decremented and one new request is replayed. Edges that coincide with a completion are never lost.

Top module: `edge_irq_gateway`

## Requirements
- R1: A synchronous active-high reset clears the request line, the in-flight state and the pending counter, so a completion strobe after reset produces no request.
- R2: On an idle gateway, a rising edge on `rawIrq` asserts `irqReq` on the third rising clock edge after `rawIrq` is first sampled high, and not earlier.
- R3: Only a low-to-high transition counts as an edge. A `rawIrq` held high raises exactly one request.
- R4: A claim strobe while `irqReq` is high drives `irqReq` low on the next cycle. A claim does not re-open the gateway: edges after a claim and before completion raise no request.
- R5: A completion strobe while a request is in flight, with nothing pending and no coinciding edge, returns the gateway to idle with `irqReq` low, whether or not the request was claimed.
- R6: In ignore mode (`COUNT_EDGES` = 0), edges that arrive while a request is in flight are permanently lost, and no request follows the completion.
- R7: In count mode (`COUNT_EDGES` = 1), each edge during an in-flight request adds one to the pending count. Each completion with a non-zero count decrements it and raises `irqReq` on the following cycle.
- R8: The pending counter saturates at 2^`PEND_WIDTH`-1 and never wraps. With `PEND_WIDTH` = 2, five edges during one request yield exactly three replays.
- R9: An edge detected in the same cycle as a completion is not lost: in both modes the gateway issues a new request on the next cycle, and the pending count is not changed.
- R10: A completion strobe while no request is in flight has no effect. The gateway still answers the next edge normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rawIrq | input | 1 | Asynchronous raw interrupt line from the source |
| claimStb | input | 1 | Single-cycle claim strobe from the controller core |
| completeStb | input | 1 | Single-cycle completion strobe from the controller core |
| irqReq | output | 1 | Level interrupt request toward the controller core |

## Verification
The assertions assume that claim and completion arrive as single-cycle strobes. They also assume that `rawIrq` stays at each level for at least as many cycles as the synchroniser has stages, so that every edge is seen as one clean one-cycle pulse. The bench drives all strobes for exactly one cycle on the falling clock edge. It holds every raw pulse high for two cycles and low for at least three. One stimulus stream drives a count-mode instance and an ignore-mode instance side by side, so the same sequence shows both the replay case and the loss case.

// File: rtl/gateway_pkg.sv
package gateway_pkg;
  // Strobes from the control to the pending-count datapath
  typedef struct packed {
    logic incPend;
    logic decPend;
  } pendCtl_t;
endpackage

// File: rtl/gw_edge_sync.sv
module gw_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic riseSeen
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (rst) shiftQ <= '0;
    else     shiftQ <= {shiftQ[CHAIN-2:0], rawIn};
  end

  // Newest synchronised sample high, one cycle older sample low
  assign riseSeen = shiftQ[SYNC_STAGES-1] & ~shiftQ[SYNC_STAGES];

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    riseSeen |=> !riseSeen);
endmodule

// File: rtl/gw_pend_cnt.sv
module gw_pend_cnt
  import gateway_pkg::*;
#(
  parameter int PEND_WIDTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  pendCtl_t pendCtl,
  output logic     pendNonZero
);
  localparam logic [PEND_WIDTH-1:0] PEND_MAX = {PEND_WIDTH{1'b1}};

  logic [PEND_WIDTH-1:0] pendQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= '0;
    end else if (pendCtl.incPend) begin
      if (pendQ != PEND_MAX) pendQ <= pendQ + 1'b1;
    end else if (pendCtl.decPend) begin
      pendQ <= pendQ - 1'b1;
    end
  end

  assign pendNonZero = |pendQ;

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pendQ == PEND_MAX && pendCtl.incPend) |=> pendQ == PEND_MAX);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pendCtl.decPend |-> pendQ != '0);

  // R7
  exclusive_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pendCtl.incPend && pendCtl.decPend));
endmodule

// File: rtl/gw_ctrl.sv
module gw_ctrl
  import gateway_pkg::*;
#(
  parameter int COUNT_EDGES = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     riseSeen,
  input  logic     claimStb,
  input  logic     completeStb,
  input  logic     pendNonZero,
  output logic     reqLine,
  output pendCtl_t pendCtl
);
  localparam bit COUNTING = (COUNT_EDGES != 0);

  logic inFlight;
  logic doneNow;

  assign doneNow = completeStb & inFlight;

  always_comb begin
    pendCtl = '0;
    // An edge that coincides with a completion becomes the replay itself
    pendCtl.decPend = doneNow & pendNonZero & ~riseSeen;
    pendCtl.incPend = COUNTING & inFlight & ~completeStb & riseSeen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqLine  <= 1'b0;
      inFlight <= 1'b0;
    end else if (!inFlight) begin
      if (riseSeen) begin
        reqLine  <= 1'b1;
        inFlight <= 1'b1;
      end
    end else if (completeStb) begin
      if (riseSeen || pendNonZero) begin
        reqLine <= 1'b1;
      end else begin
        reqLine  <= 1'b0;
        inFlight <= 1'b0;
      end
    end else if (claimStb) begin
      reqLine <= 1'b0;
    end
  end

  // R1
  req_implies_flight_chk: assert property (@(posedge clk) disable iff (rst)
    reqLine |-> inFlight);

  // R4
  claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (claimStb && reqLine && !completeStb) |=> !reqLine);

  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (inFlight && !reqLine && !completeStb) |=> !reqLine);

  // R10
  idle_complete_chk: assert property (@(posedge clk) disable iff (rst)
    (!inFlight && !riseSeen) |=> !reqLine);
endmodule

// File: rtl/edge_irq_gateway.sv
module edge_irq_gateway
  import gateway_pkg::*;
#(
  parameter int COUNT_EDGES = 1,
  parameter int PEND_WIDTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIrq,
  input  logic claimStb,
  input  logic completeStb,
  output logic irqReq
);
  logic     riseSeen;
  logic     pendNonZero;
  pendCtl_t pendCtl;

  gw_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .rawIn    (rawIrq),
    .riseSeen (riseSeen)
  );

  gw_ctrl #(.COUNT_EDGES(COUNT_EDGES)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .riseSeen    (riseSeen),
    .claimStb    (claimStb),
    .completeStb (completeStb),
    .pendNonZero (pendNonZero),
    .reqLine     (irqReq),
    .pendCtl     (pendCtl)
  );

  generate
    if (COUNT_EDGES != 0) begin : g_count
      gw_pend_cnt #(.PEND_WIDTH(PEND_WIDTH)) i_pend (
        .clk         (clk),
        .rst         (rst),
        .pendCtl     (pendCtl),
        .pendNonZero (pendNonZero)
      );
    end else begin : g_ignore
      assign pendNonZero = 1'b0;
    end
  endgenerate
endmodule

// File: tb/test_edge_irq_gateway.sv
module test_edge_irq_gateway;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawIrq = 1'b0;
  logic claimStb = 1'b0;
  logic completeStb = 1'b0;
  logic reqCnt, reqIgn;
  int   nChecks = 0;
  int   nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_gateway #(.COUNT_EDGES(1), .PEND_WIDTH(2)) i_edge_irq_gateway (
    .clk(clk), .rst(rst), .rawIrq(rawIrq), .claimStb(claimStb),
    .completeStb(completeStb), .irqReq(reqCnt));

  edge_irq_gateway #(.COUNT_EDGES(0), .PEND_WIDTH(2)) i_edge_irq_gateway_ign (
    .clk(clk), .rst(rst), .rawIrq(rawIrq), .claimStb(claimStb),
    .completeStb(completeStb), .irqReq(reqIgn));

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Edge, then low long enough for the synchroniser; a request is visible at return
  task automatic pulseRaw();
    rawIrq = 1'b1; cyc(2); rawIrq = 1'b0; cyc(3);
  endtask

  task automatic doClaim();
    claimStb = 1'b1; cyc(1); claimStb = 1'b0;
  endtask

  task automatic doComplete();
    completeStb = 1'b1; cyc(1); completeStb = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 cnt reset", reqCnt, 1'b0);
    chk("R1 ign reset", reqIgn, 1'b0);
    doComplete();
    chk("R1 cnt complete after reset", reqCnt, 1'b0);
    chk("R1 ign complete after reset", reqIgn, 1'b0);
  endtask

  task automatic testLatencyAndLevel();
    rawIrq = 1'b1; cyc(2);
    chk("R2 not before third edge", reqCnt, 1'b0);
    cyc(1);
    chk("R2 cnt request", reqCnt, 1'b1);
    chk("R2 ign request", reqIgn, 1'b1);
    doClaim();
    chk("R4 claim clears cnt", reqCnt, 1'b0);
    chk("R4 claim clears ign", reqIgn, 1'b0);
    cyc(6);
    chk("R3 held level no new req", reqCnt, 1'b0);
    rawIrq = 1'b0; cyc(3);
    doComplete();
    chk("R3 level counted once", reqCnt, 1'b0);
    chk("R5 ign idle after complete", reqIgn, 1'b0);
  endtask

  task automatic testCountVsIgnore();
    pulseRaw();
    chk("R2 cnt req", reqCnt, 1'b1);
    doClaim();
    pulseRaw(); pulseRaw();
    chk("R4 claim does not reopen cnt", reqCnt, 1'b0);
    chk("R4 claim does not reopen ign", reqIgn, 1'b0);
    doComplete();
    chk("R7 first replay", reqCnt, 1'b1);
    chk("R6 ignored edges lost", reqIgn, 1'b0);
    doClaim(); doComplete();
    chk("R7 second replay", reqCnt, 1'b1);
    chk("R6 ign still idle", reqIgn, 1'b0);
    doClaim(); doComplete();
    chk("R7 count drained", reqCnt, 1'b0);
  endtask

  task automatic testSaturation();
    int replays = 0;
    pulseRaw();
    doClaim();
    for (int i = 0; i < 5; i++) pulseRaw();
    for (int i = 0; i < 4; i++) begin
      doComplete();
      chk("R8 replay pattern", reqCnt, (i < 3) ? 1'b1 : 1'b0);
      if (reqCnt === 1'b1) replays++;
      doClaim();
    end
    nChecks++;
    if (replays != 3) begin
      nFail++;
      $display("FAIL R8 replays actual=%0d expected=3", replays);
    end
    chk("R6 ign lost all", reqIgn, 1'b0);
  endtask

  task automatic testEdgeAtCompletion();
    pulseRaw();
    doClaim();
    rawIrq = 1'b1; cyc(2);
    completeStb = 1'b1; cyc(1); completeStb = 1'b0;
    rawIrq = 1'b0;
    chk("R9 cnt coincident edge", reqCnt, 1'b1);
    chk("R9 ign coincident edge", reqIgn, 1'b1);
    cyc(3);
    doClaim(); doComplete();
    chk("R9 cnt count unchanged", reqCnt, 1'b0);
    chk("R9 ign back to idle", reqIgn, 1'b0);
  endtask

  task automatic testIdleComplete();
    doComplete();
    chk("R10 cnt idle complete", reqCnt, 1'b0);
    chk("R10 ign idle complete", reqIgn, 1'b0);
    pulseRaw();
    chk("R10 cnt edge still served", reqCnt, 1'b1);
    doComplete();
    chk("R5 unclaimed completion idles", reqCnt, 1'b0);
    chk("R5 ign unclaimed completion", reqIgn, 1'b0);
    cyc(3);
    chk("R5 stays idle", reqCnt, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    testReset();
    testLatencyAndLevel();
    testCountVsIgnore();
    testSaturation();
    testEdgeAtCompletion();
    testIdleComplete();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule